// File: doc/BRIEF.md
# Ramped Stereo Volume Attenuator

This block scales a stereo pair of signed audio samples by a shared coefficient. The coefficient is the attenuation register divided by 256. A gain-enable flag selects between the register and unity gain. The applied coefficient never jumps. When the target changes, it walks one unit at a time toward the target, and it advances once every four sample strobes. This keeps gain changes free of audible steps.

Settings arrive as command writes, each made of an 8-bit code and an 8-bit data byte. Samples enter together with a one-cycle strobe. The scaled pair leaves one clock later, with its own valid pulse. A settled output shows when the applied coefficient has reached the current target.

Top module: `vol_ramp`

## Requirements
- R1: After reset the attenuation register holds 64 and the enable flag is 0. The applied coefficient is 256, `settled` is high, and output samples equal input samples.
- R2: A write with code 0x84 loads `cmd_data` into the attenuation register. A write with code 0x83 loads `cmd_data` bit 0 into the enable flag. A write with any other code changes neither and leaves the outputs unchanged.
- R3: The target is the register value when the flag is 1, and 256 when the flag is 0. While the flag is 0, register writes do not alter the output gain.
- R4: On each cycle with `smp_valid` high, the block takes both inputs. One cycle later `out_valid` is high and each output equals floor(input × coef / 256), using the coefficient held before that same edge.
- R5: A 2-bit counter advances on every strobe. On a strobe where the counter is 3 and the coefficient differs from the target, the coefficient moves exactly 1 toward the target.
- R6: An accepted write (code 0x83 or 0x84) made while `settled` is high resets the counter to 0. The first step therefore happens on the fourth strobe after that write.
- R7: A target change during a ramp does not reset the counter. The ramp turns toward the newest target from the current coefficient.
- R8: `settled` is high exactly when the applied coefficient equals the target, and the coefficient does not move while `settled` is high.
- R9: The coefficient stays within 0 to 256. A register value of 255 gives outputs of input × 255/256, and a value of 0 gives outputs of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code |
| cmd_data | input | 8 | Command data byte |
| smp_valid | input | 1 | Sample strobe |
| left_in | input | W | Left sample in, signed |
| right_in | input | W | Right sample in, signed |
| out_valid | output | 1 | Output sample strobe |
| left_out | output | W | Scaled left sample, signed |
| right_out | output | W | Scaled right sample, signed |
| settled | output | 1 | Coefficient equals target |

## Verification
The hardest case to reach is a retarget in the middle of a ramp, with the counter phase left intact. The stimulus enables gain so a long downward ramp begins. After a few steps it writes a new register value on the far side of the current coefficient, so the ramp reverses without a counter restart. Every sample uses a unit-scaled input of 256, so each output word shows the applied coefficient directly. This lets the four-strobe step cadence and the turning point be compared sample by sample. Long ramps to 255, to 0 and back to unity cover the ends of the range.

// File: rtl/vol_ramp.sv
module vol_ramp #(
  parameter int W = 16,
  parameter logic [7:0] CODE_ATT = 8'h84,
  parameter logic [7:0] CODE_EN  = 8'h83,
  parameter logic [7:0] ATT_INIT = 8'd64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_we,
  input  logic [7:0]          cmd_code,
  input  logic [7:0]          cmd_data,
  input  logic                smp_valid,
  input  logic signed [W-1:0] left_in,
  input  logic signed [W-1:0] right_in,
  output logic                out_valid,
  output logic signed [W-1:0] left_out,
  output logic signed [W-1:0] right_out,
  output logic                settled
);
  localparam int PW = W + 10;
  localparam logic [8:0] UNITY = 9'd256;

  logic [7:0] att_q;
  logic       en_q;
  logic [8:0] coef_q;
  logic [1:0] cnt_q;
  logic [8:0] tgt;
  logic       wr_att, wr_en, tick;
  logic signed [PW-1:0] pl, pr;

  assign tgt     = en_q ? {1'b0, att_q} : UNITY;
  assign settled = (coef_q == tgt);
  assign wr_att  = cmd_we && (cmd_code == CODE_ATT);
  assign wr_en   = cmd_we && (cmd_code == CODE_EN);
  assign tick    = smp_valid && (cnt_q == 2'd3);
  assign pl      = left_in  * $signed({1'b0, coef_q});
  assign pr      = right_in * $signed({1'b0, coef_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      att_q <= ATT_INIT;
      en_q  <= 1'b0;
    end else begin
      if (wr_att) att_q <= cmd_data;
      if (wr_en)  en_q  <= cmd_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= 2'd0;
    else if ((wr_att || wr_en) && settled)
      cnt_q <= 2'd0;
    else if (smp_valid)
      cnt_q <= cnt_q + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      coef_q <= UNITY;
    else if (tick && !settled)
      coef_q <= (coef_q < tgt) ? coef_q + 9'd1 : coef_q - 9'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      left_out  <= '0;
      right_out <= '0;
    end else begin
      out_valid <= smp_valid;
      if (smp_valid) begin
        left_out  <= pl[W+7:8];
        right_out <= pr[W+7:8];
      end
    end
  end

  assert_coef_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    coef_q <= UNITY);

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_q == $past(coef_q)) || (coef_q == $past(coef_q) + 9'd1) ||
    (coef_q + 9'd1 == $past(coef_q)));

  assert_hold_when_settled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    settled |=> $stable(coef_q));

  assert_no_move_without_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(coef_q));

  assert_out_follows_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);

  assert_toward_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_q < tgt) |=> (coef_q >= $past(coef_q)));
endmodule

// File: tb/vol_ramp_test.sv
module vol_ramp_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [7:0] cmd_code = '0, cmd_data = '0;
  logic smp_valid = 1'b0;
  logic signed [W-1:0] left_in = '0, right_in = '0;
  logic out_valid, settled;
  logic signed [W-1:0] left_out, right_out;

  vol_ramp #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .cmd_data(cmd_data), .smp_valid(smp_valid), .left_in(left_in),
    .right_in(right_in), .out_valid(out_valid), .left_out(left_out),
    .right_out(right_out), .settled(settled)
  );

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int m_reg = 64, m_en = 0, m_coef = 256, m_cnt = 0;
  int ql[$], qr[$], qs[$], qtag[$];

  function automatic int m_tgt();
    return m_en ? m_reg : 256;
  endfunction

  function automatic int scale(int x, int c);
    return (x * c) >>> 8;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sample(int l, int r, int tag);
    @(negedge clk);
    smp_valid = 1'b1; left_in = W'(l); right_in = W'(r);
    ql.push_back(scale(l, m_coef)); qr.push_back(scale(r, m_coef));
    if (m_cnt == 3 && m_coef != m_tgt())
      m_coef += (m_coef < m_tgt()) ? 1 : -1;
    m_cnt = (m_cnt + 1) % 4;
    qs.push_back(m_coef == m_tgt());
    qtag.push_back(tag);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic write(int code, int data);
    @(negedge clk);
    cmd_we = 1'b1; cmd_code = 8'(code); cmd_data = 8'(data);
    if (code == 'h84 || code == 'h83) begin
      if (m_coef == m_tgt()) m_cnt = 0;
      if (code == 'h84) m_reg = data; else m_en = data & 1;
    end
    @(negedge clk);
    cmd_we = 1'b0;
    check("R8 settled after write", settled, m_coef == m_tgt());
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (ql.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R4: actual unexpected output expected none");
      end else begin
        int el, er, es, tg;
        el = ql.pop_front(); er = qr.pop_front(); es = qs.pop_front(); tg = qtag.pop_front();
        check($sformatf("R4 left (R%0d)", tg), int'(left_out), el);
        check($sformatf("R4 right (R%0d)", tg), int'(right_out), er);
        check("R8 settled", int'(settled), es);
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 settled at reset", settled, 1);
    check("R1 no output at reset", out_valid, 0);
    sample(1000, -1000, 1);
    sample(256, -256, 1);
    // R3: register write while disabled leaves unity gain
    write('h84, 128);
    sample(256, 12345, 3);
    check("R3 still settled", settled, 1);
    // R2: unknown code ignored
    write('h85, 0);
    write('h82, 1);
    sample(-32768, 32767, 2);
    // R6: enable while settled restarts counter, ramp toward 128
    write('h83, 1);
    for (int i = 0; i < 20; i++) sample(256, -777, 6);
    // R7: retarget mid-ramp above current position
    write('h84, 254);
    for (int i = 0; i < 10; i++) sample(256, 300, 7);
    write('h84, 200);
    for (int i = 0; i < 300 && m_coef != m_tgt(); i++) sample(256, -5, 7);
    check("R7 reached target", settled, 1);
    // R9: top of range
    write('h84, 255);
    for (int i = 0; i < 400 && m_coef != m_tgt(); i++) sample(256, 1000, 5);
    sample(-1000, 32767, 9);
    sample(-1, 1, 9);
    // R9: zero gain
    write('h84, 0);
    for (int i = 0; i < 1100 && m_coef != m_tgt(); i++) sample(256, -1, 5);
    sample(32767, -32768, 9);
    // R3: disabling ramps back to unity
    write('h83, 0);
    for (int i = 0; i < 1100 && m_coef != m_tgt(); i++) sample(256, 99, 3);
    sample(-1234, 4321, 3);
    check("R9 back at unity settled", settled, 1);
    @(negedge clk);
    @(negedge clk);
    check("R4 queue drained", ql.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule